// File: doc/BRIEF.md
# Machine-Cycle Sequencer with DMA and Interrupt Arbitration

This block chooses the kind of each machine cycle for a small 8-bit processor core. The four kinds are instruction fetch, instruction execute, DMA transfer and interrupt acknowledge. A timing generator outside the block supplies two one-clock strobes in every machine cycle. The early strobe (`tpa`) loads the 2-bit state code seen by the outside world. The late strobe (`tpb`) closes the current cycle, and the next cycle kind is chosen at that moment.

DMA requests are looked at in execute, DMA, acknowledge and idle cycles. Interrupt requests are looked at only in execute, DMA and idle cycles. Within one instruction, requests are looked at only when the core marks the last execute cycle. Arbitration follows a fixed order: DMA-in first, then DMA-out, then an enabled interrupt. The interrupt request is never stored, so it must still be present at the deciding strobe.

On acknowledge, the block keeps the data and program designators in a save register. It then forces them to fixed values and clears the interrupt enable. Each DMA cycle ends with a one-clock increment command for the DMA address pointer. An idle instruction holds the sequencer in a low-power wait. The wait ends only when a DMA request or an enabled interrupt is present at a `tpb`.

States: FETCH, EXEC, DMA_IN, DMA_OUT, INTACK, IDLE. Transitions, each taken only on `tpb`:
- FETCH→EXEC.
- EXEC→EXEC while the cycle is not the last one.
- EXEC→DMA_IN, DMA_OUT, INTACK, IDLE or FETCH at the last cycle. Requests rank above the idle command.
- DMA_*→DMA_IN, DMA_OUT, INTACK or FETCH.
- INTACK→DMA_IN, DMA_OUT or FETCH.
- IDLE→DMA_IN, DMA_OUT or INTACK. Otherwise it stays in IDLE.

Top module: `cycle_sequencer`

## Requirements
- R1: During and right after reset: state code 00, interrupt enable 1, X = P = T = 0, idle flag 0, increment command 0.
- R2: The state code shows the cycle in progress and loads only on clocks where `tpa` is 1. Codes: 00 = fetch, 01 = execute or idle, 10 = DMA, 11 = interrupt acknowledge.
- R3: The cycle kind changes only on clocks where `tpb` is 1. A fetch is always followed by an execute. An execute repeats while `exec_last` is 0.
- R4: At a deciding `tpb`, the next cycle is chosen in this order: DMA-in, then DMA-out, then interrupt (only with enable 1), then fetch. A deciding `tpb` is one that ends the last execute, a DMA, an acknowledge or an idle cycle.
- R5: The interrupt request is not looked at when an acknowledge cycle ends, and it is not stored. A request that drops before the deciding `tpb` causes no acknowledge.
- R6: On the `tpb` that enters an acknowledge: T takes {X,P}, X becomes 2, P becomes 1 and the enable becomes 0. A designator or enable write from the core in that same clock is ignored.
- R7: `ptr_inc` is high for exactly the one clock after each `tpb` that ends a DMA cycle. `dma_to_mem` is 1 during DMA-in cycles and 0 in all other cycles.
- R8: When `idle_cmd` is 1 at the end of the last execute and no request wins, the block enters idle. In idle, `idle_o` is 1 and the code is 01. Only a DMA request or an enabled interrupt at a `tpb` ends idle.
- R9: With the enable at 0, an interrupt request never causes an acknowledge cycle.
- R10: Outside an acknowledge entry, `des_load` loads X and P from `x_in` and `p_in`, and `ie_write` loads the enable from `ie_in`. Both take effect at the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tpa | input | 1 | Early strobe of each machine cycle |
| tpb | input | 1 | Late strobe of each machine cycle; the next cycle is decided here |
| dma_in_req | input | 1 | DMA request, device to memory |
| dma_out_req | input | 1 | DMA request, memory to device |
| irq_req | input | 1 | Interrupt request (level, not stored) |
| exec_last | input | 1 | The current execute cycle is the last one of the instruction |
| idle_cmd | input | 1 | The instruction being executed is the idle instruction |
| des_load | input | 1 | Load X and P from the core |
| x_in | input | DES_W | New data designator |
| p_in | input | DES_W | New program designator |
| ie_write | input | 1 | Write the interrupt enable |
| ie_in | input | 1 | New interrupt enable value |
| state_code | output | 2 | Cycle kind code, loaded at `tpa` |
| x_o | output | DES_W | Data designator |
| p_o | output | DES_W | Program designator |
| t_o | output | 2*DES_W | Saved {X,P} |
| ie_o | output | 1 | Interrupt enable |
| ptr_inc | output | 1 | One-clock increment command for the DMA pointer |
| dma_to_mem | output | 1 | Current cycle is a DMA-in cycle |
| idle_o | output | 1 | Sequencer is in idle |

## Verification
Random phases mix sparse requests, multi-cycle instructions and core designator writes. A cycle-accurate model in the bench separates the correct order from wrong priority, wrong windows and wrong strobe timing. A phase that holds all three requests high at once separates the strict DMA-in precedence from any fair or reversed order. A phase where the interrupt pulses and falls before each `tpb` separates a level-sampled request from a latched one. An idle phase with no requests and then a single interrupt separates a true wait from an early exit, and checks that only a real request ends idle.

// File: rtl/seqr_pkg.sv
package seqr_pkg;
    typedef enum logic [2:0] {
        CY_FETCH,
        CY_EXEC,
        CY_DMA_IN,
        CY_DMA_OUT,
        CY_INTACK,
        CY_IDLE
    } cyc_e;

    typedef enum logic [1:0] {
        GR_NONE,
        GR_DIN,
        GR_DOUT,
        GR_INT
    } grant_e;

    localparam logic [1:0] CODE_FETCH = 2'b00;
    localparam logic [1:0] CODE_EXEC  = 2'b01;
    localparam logic [1:0] CODE_DMA   = 2'b10;
    localparam logic [1:0] CODE_INT   = 2'b11;

    function automatic logic [1:0] cyc_code(cyc_e c);
        logic [1:0] r;
        unique case (c)
            CY_FETCH:             r = CODE_FETCH;
            CY_EXEC, CY_IDLE:     r = CODE_EXEC;
            CY_DMA_IN, CY_DMA_OUT: r = CODE_DMA;
            CY_INTACK:            r = CODE_INT;
            default:              r = CODE_FETCH;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/seqr_arbiter.sv
module seqr_arbiter
    import seqr_pkg::*;
(
    input  logic   dma_win,
    input  logic   irq_win,
    input  logic   dma_in_req,
    input  logic   dma_out_req,
    input  logic   irq_req,
    input  logic   ie,
    output grant_e grant
);
    always_comb begin
        if (dma_win && dma_in_req)
            grant = GR_DIN;
        else if (dma_win && dma_out_req)
            grant = GR_DOUT;
        else if (irq_win && irq_req && ie)
            grant = GR_INT;
        else
            grant = GR_NONE;
    end
endmodule

// File: rtl/seqr_fsm.sv
module seqr_fsm
    import seqr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tpb,
    input  logic dma_in_req,
    input  logic dma_out_req,
    input  logic irq_req,
    input  logic ie,
    input  logic exec_last,
    input  logic idle_cmd,
    output cyc_e cyc_q,
    output logic irq_take,
    output logic dma_end
);
    cyc_e   cyc_d;
    grant_e grant;
    logic   decide;
    logic   dma_win;
    logic   irq_win;

    always_comb begin
        unique case (cyc_q)
            CY_FETCH:                  decide = 1'b0;
            CY_EXEC:                   decide = exec_last;
            CY_DMA_IN, CY_DMA_OUT:     decide = 1'b1;
            CY_INTACK, CY_IDLE:        decide = 1'b1;
            default:                   decide = 1'b0;
        endcase
    end

    assign dma_win = decide;
    assign irq_win = decide && (cyc_q != CY_INTACK);

    seqr_arbiter u_arb (
        .dma_win    (dma_win),
        .irq_win    (irq_win),
        .dma_in_req (dma_in_req),
        .dma_out_req(dma_out_req),
        .irq_req    (irq_req),
        .ie         (ie),
        .grant      (grant)
    );

    function automatic cyc_e grant_cyc(grant_e g, cyc_e dflt);
        cyc_e r;
        unique case (g)
            GR_DIN:  r = CY_DMA_IN;
            GR_DOUT: r = CY_DMA_OUT;
            GR_INT:  r = CY_INTACK;
            default: r = dflt;
        endcase
        return r;
    endfunction

    always_comb begin
        cyc_d = cyc_q;
        if (tpb) begin
            unique case (cyc_q)
                CY_FETCH:   cyc_d = CY_EXEC;
                CY_EXEC: begin
                    if (exec_last)
                        cyc_d = grant_cyc(grant, idle_cmd ? CY_IDLE : CY_FETCH);
                end
                CY_DMA_IN:  cyc_d = grant_cyc(grant, CY_FETCH);
                CY_DMA_OUT: cyc_d = grant_cyc(grant, CY_FETCH);
                CY_INTACK:  cyc_d = grant_cyc(grant, CY_FETCH);
                CY_IDLE:    cyc_d = grant_cyc(grant, CY_IDLE);
                default:    cyc_d = CY_FETCH;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cyc_q <= CY_FETCH;
        else
            cyc_q <= cyc_d;
    end

    assign irq_take = tpb && (cyc_d == CY_INTACK) && (cyc_q != CY_INTACK);
    assign dma_end  = tpb && ((cyc_q == CY_DMA_IN) || (cyc_q == CY_DMA_OUT));
endmodule

// File: rtl/seqr_context.sv
module seqr_context #(
    parameter int DES_W = 4,
    parameter int X_ACK = 2,
    parameter int P_ACK = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               irq_take,
    input  logic               des_load,
    input  logic [DES_W-1:0]   x_in,
    input  logic [DES_W-1:0]   p_in,
    input  logic               ie_write,
    input  logic               ie_in,
    output logic [DES_W-1:0]   x_q,
    output logic [DES_W-1:0]   p_q,
    output logic [2*DES_W-1:0] t_q,
    output logic               ie_q
);
    localparam logic [DES_W-1:0] XA = DES_W'(X_ACK);
    localparam logic [DES_W-1:0] PA = DES_W'(P_ACK);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q  <= '0;
            p_q  <= '0;
            t_q  <= '0;
            ie_q <= 1'b1;
        end else if (irq_take) begin
            t_q  <= {x_q, p_q};
            x_q  <= XA;
            p_q  <= PA;
            ie_q <= 1'b0;
        end else begin
            if (des_load) begin
                x_q <= x_in;
                p_q <= p_in;
            end
            if (ie_write)
                ie_q <= ie_in;
        end
    end
endmodule

// File: rtl/seqr_outputs.sv
module seqr_outputs
    import seqr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tpa,
    input  cyc_e       cyc_q,
    input  logic       dma_end,
    output logic [1:0] state_code,
    output logic       ptr_inc,
    output logic       dma_to_mem,
    output logic       idle_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_code <= CODE_FETCH;
            ptr_inc    <= 1'b0;
        end else begin
            if (tpa)
                state_code <= cyc_code(cyc_q);
            ptr_inc <= dma_end;
        end
    end

    always_comb begin
        dma_to_mem = (cyc_q == CY_DMA_IN);
        idle_o     = (cyc_q == CY_IDLE);
    end
endmodule

// File: rtl/cycle_sequencer.sv
module cycle_sequencer
    import seqr_pkg::*;
#(
    parameter int DES_W = 4,
    parameter int X_ACK = 2,
    parameter int P_ACK = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tpa,
    input  logic               tpb,
    input  logic               dma_in_req,
    input  logic               dma_out_req,
    input  logic               irq_req,
    input  logic               exec_last,
    input  logic               idle_cmd,
    input  logic               des_load,
    input  logic [DES_W-1:0]   x_in,
    input  logic [DES_W-1:0]   p_in,
    input  logic               ie_write,
    input  logic               ie_in,
    output logic [1:0]         state_code,
    output logic [DES_W-1:0]   x_o,
    output logic [DES_W-1:0]   p_o,
    output logic [2*DES_W-1:0] t_o,
    output logic               ie_o,
    output logic               ptr_inc,
    output logic               dma_to_mem,
    output logic               idle_o
);
    cyc_e cyc_q;
    logic irq_take;
    logic dma_end;

    seqr_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tpb        (tpb),
        .dma_in_req (dma_in_req),
        .dma_out_req(dma_out_req),
        .irq_req    (irq_req),
        .ie         (ie_o),
        .exec_last  (exec_last),
        .idle_cmd   (idle_cmd),
        .cyc_q      (cyc_q),
        .irq_take   (irq_take),
        .dma_end    (dma_end)
    );

    seqr_context #(.DES_W(DES_W), .X_ACK(X_ACK), .P_ACK(P_ACK)) u_ctx (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_take(irq_take),
        .des_load(des_load),
        .x_in    (x_in),
        .p_in    (p_in),
        .ie_write(ie_write),
        .ie_in   (ie_in),
        .x_q     (x_o),
        .p_q     (p_o),
        .t_q     (t_o),
        .ie_q    (ie_o)
    );

    seqr_outputs u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .tpa       (tpa),
        .cyc_q     (cyc_q),
        .dma_end   (dma_end),
        .state_code(state_code),
        .ptr_inc   (ptr_inc),
        .dma_to_mem(dma_to_mem),
        .idle_o    (idle_o)
    );
endmodule

// File: rtl/seqr_checker.sv
module seqr_checker
    import seqr_pkg::*;
#(
    parameter int DES_W = 4,
    parameter int X_ACK = 2,
    parameter int P_ACK = 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tpa,
    input logic               tpb,
    input logic               dma_in_req,
    input logic               exec_last,
    input logic [1:0]         state_code,
    input logic [DES_W-1:0]   x_o,
    input logic [DES_W-1:0]   p_o,
    input logic [2*DES_W-1:0] t_o,
    input logic               ie_o,
    input logic               ptr_inc,
    input cyc_e               cyc_q,
    input logic               irq_take
);
    assert_code_on_tpa_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tpa |=> $stable(state_code));

    assert_hold_without_tpb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tpb |=> $stable(cyc_q));

    assert_fetch_to_exec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tpb && cyc_q == CY_FETCH) |=> (cyc_q == CY_EXEC));

    assert_dma_in_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tpb && dma_in_req && cyc_q != CY_FETCH && !(cyc_q == CY_EXEC && !exec_last))
        |=> (cyc_q == CY_DMA_IN));

    assert_ack_context_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |=> (x_o == DES_W'(X_ACK) && p_o == DES_W'(P_ACK) && !ie_o
                      && t_o == $past({x_o, p_o})));

    assert_ptr_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_inc |=> !ptr_inc);

    assert_no_ack_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tpb && !ie_o) |=> (cyc_q != CY_INTACK));
endmodule

bind cycle_sequencer seqr_checker #(.DES_W(DES_W), .X_ACK(X_ACK), .P_ACK(P_ACK)) u_seqr_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tpa       (tpa),
    .tpb       (tpb),
    .dma_in_req(dma_in_req),
    .exec_last (exec_last),
    .state_code(state_code),
    .x_o       (x_o),
    .p_o       (p_o),
    .t_o       (t_o),
    .ie_o      (ie_o),
    .ptr_inc   (ptr_inc),
    .cyc_q     (cyc_q),
    .irq_take  (irq_take)
);

// File: tb/test_cycle_sequencer.sv
module test_cycle_sequencer;
    localparam int DW = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, tpa, tpb, dma_in_req, dma_out_req, irq_req, exec_last, idle_cmd;
    logic des_load, ie_write, ie_in;
    logic [DW-1:0] x_in, p_in, x_o, p_o;
    logic [2*DW-1:0] t_o;
    logic [1:0] state_code;
    logic ie_o, ptr_inc, dma_to_mem, idle_o;

    cycle_sequencer #(.DES_W(DW)) i_cycle_sequencer (
        .clk(clk), .rst_n(rst_n), .tpa(tpa), .tpb(tpb),
        .dma_in_req(dma_in_req), .dma_out_req(dma_out_req), .irq_req(irq_req),
        .exec_last(exec_last), .idle_cmd(idle_cmd), .des_load(des_load),
        .x_in(x_in), .p_in(p_in), .ie_write(ie_write), .ie_in(ie_in),
        .state_code(state_code), .x_o(x_o), .p_o(p_o), .t_o(t_o), .ie_o(ie_o),
        .ptr_inc(ptr_inc), .dma_to_mem(dma_to_mem), .idle_o(idle_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    int ph = 0;
    int ack_seen = 0;
    bit finished = 0;

    // model state: 0 fetch, 1 exec, 2 dma-in, 3 dma-out, 4 ack, 5 idle
    int m_s;
    logic [1:0] m_sc;
    logic [DW-1:0] m_x, m_p;
    logic [2*DW-1:0] m_t;
    logic m_ie, m_ptr;

    function automatic logic [1:0] code_of(int s);
        case (s)
            0: return 2'b00;
            1, 5: return 2'b01;
            2, 3: return 2'b10;
            default: return 2'b11;
        endcase
    endfunction

    // R3 R4 R5 R8 R9: next cycle at a tpb
    function automatic int next_of(int s, bit di, bit dout, bit irq, bit ie, bit last, bit idl);
        bit dec;
        int dflt;
        dec = (s == 1) ? last : (s != 0);
        if (s == 0) return 1;
        if (!dec) return s;
        dflt = (s == 5) ? 5 : ((s == 1 && idl) ? 5 : 0);
        if (di) return 2;
        if (dout) return 3;
        if (irq && ie && s != 4) return 4;
        return dflt;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R2 state code", 32'(state_code), 32'(m_sc));
        chk("R6 R10 X designator", 32'(x_o), 32'(m_x));
        chk("R6 R10 P designator", 32'(p_o), 32'(m_p));
        chk("R6 saved T", 32'(t_o), 32'(m_t));
        chk("R6 R9 R10 interrupt enable", 32'(ie_o), 32'(m_ie));
        chk("R7 pointer increment", 32'(ptr_inc), 32'(m_ptr));
        chk("R7 DMA direction / R3 R4 R5 cycle order", 32'(dma_to_mem), 32'(m_s == 2));
        chk("R8 idle flag", 32'(idle_o), 32'(m_s == 5));
    endtask

    // mode 0 random, 1 all requests, 2 irq drops before tpb, 3 idle quiet, 4 idle then irq
    task automatic step(int mode);
        int nx;
        bit take;
        @(negedge clk);
        compare_all();
        if (state_code == 2'b11) ack_seen++;
        tpa = (ph == 1);
        tpb = (ph == 5);
        case (mode)
            1: begin
                dma_in_req = 1; dma_out_req = 1; irq_req = 1;
                exec_last = 1; idle_cmd = 0; des_load = 0; ie_write = 0;
            end
            2: begin
                dma_in_req = 0; dma_out_req = 0; irq_req = (ph < 4);
                exec_last = ($urandom % 2) == 0; idle_cmd = 0; des_load = 0;
                ie_write = 1; ie_in = 1;
            end
            3: begin
                dma_in_req = 0; dma_out_req = 0; irq_req = 0;
                exec_last = 1; idle_cmd = 1; des_load = 0; ie_write = (ph == 0); ie_in = 1;
            end
            4: begin
                dma_in_req = 0; dma_out_req = 0; irq_req = 1;
                exec_last = 1; idle_cmd = 1; des_load = 0; ie_write = 0;
            end
            default: begin
                dma_in_req  = ($urandom % 10) == 0;
                dma_out_req = ($urandom % 10) == 0;
                irq_req     = ($urandom % 4) == 0;
                exec_last   = ($urandom % 5) < 3;
                idle_cmd    = ($urandom % 20) == 0;
                des_load    = ($urandom % 5) == 0;
                ie_write    = ($urandom % 10) == 0;
                ie_in       = ($urandom % 2) == 0;
            end
        endcase
        x_in = DW'($urandom);
        p_in = DW'($urandom);
        // model of the coming clock edge
        nx = tpb ? next_of(m_s, dma_in_req, dma_out_req, irq_req, m_ie, exec_last, idle_cmd) : m_s;
        take = tpb && nx == 4 && m_s != 4;
        m_ptr = tpb && (m_s == 2 || m_s == 3);
        if (tpa) m_sc = code_of(m_s);
        if (take) begin
            m_t = {m_x, m_p}; m_x = 4'd2; m_p = 4'd1; m_ie = 0;
        end else begin
            if (des_load) begin m_x = x_in; m_p = p_in; end
            if (ie_write) m_ie = ie_in;
        end
        m_s = nx;
        ph = (ph + 1) % 8;
    endtask

    initial begin
        #400000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1802));
        rst_n = 0; tpa = 0; tpb = 0; dma_in_req = 0; dma_out_req = 0; irq_req = 0;
        exec_last = 0; idle_cmd = 0; des_load = 0; ie_write = 0; ie_in = 0;
        x_in = '0; p_in = '0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 code", 32'(state_code), 0);
        chk("R1 enable", 32'(ie_o), 1);
        chk("R1 designators", 32'({x_o, p_o, t_o}), 0);
        chk("R1 idle/ptr", 32'({idle_o, ptr_inc}), 0);
        rst_n = 1;
        m_s = 0; m_sc = 0; m_x = 0; m_p = 0; m_t = 0; m_ie = 1; m_ptr = 0;
        for (int i = 0; i < 4000; i++) step(0);
        // R4 all requests at once
        for (int i = 0; i < 160; i++) step(1);
        // R5 request dropped before each tpb: no acknowledge expected
        for (int i = 0; i < 80; i++) step(0);
        ack_seen = 0;
        for (int i = 0; i < 400; i++) step(2);
        chk("R5 no acknowledge from dropped request", 32'(ack_seen), 0);
        // R8 idle wait, then exit by interrupt
        for (int i = 0; i < 400; i++) step(3);
        chk("R8 still idle without request", 32'(idle_o), 1);
        for (int i = 0; i < 64; i++) step(4);
        for (int i = 0; i < 4000; i++) step(0);
        @(negedge clk);
        compare_all();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule